// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block links two processor cores with a pair of one-way word queues. Queue 0 carries words from core 0 to core 1, and queue 1 carries words from core 1 to core 0. Each core has its own register-style port. A push strobe with a data word acts as a write to the data register. A pop strobe acts as a read of the data register. A status clear strobe acts as a write to the status register. From its own port, a core sees the queue it fills as TX and the queue it drains as RX. So the two ports see the same two queues in mirror image.

Each core sees a live 4-bit status word: {roe, wof, rdy, vld}. Bit 0 is vld (RX not empty). Bit 1 is rdy (TX not full). Bit 2 is wof, a sticky flag for a write to a full TX queue. Bit 3 is roe, a sticky flag for a read of an empty RX queue. Each core has its own pair of sticky flags. The per-core interrupt stays high while RX data waits or either sticky flag is set.

The data path is a register file, not a stream. The `rdy` and `vld` bits tell the core whether a push or a pop will take effect. A push while `rdy` is low is dropped and recorded, not stalled. A pop while `vld` is low returns zero and is recorded. Both cores may push and pop in the same cycle, and the two queues work independently.

Top module: `mbox_pair`

## Requirements
- R1: A push from core c while its TX queue (queue c) is not full stores `wdata_i[c]`. Words leave the queue in the order they were pushed.
- R2: `rdata_o[c]` shows the oldest word of queue 1-c, or zero when that queue is empty. A pop from core c removes that word at the clock edge.
- R3: Status bit 0 (vld) of core c is 1 exactly when queue 1-c holds at least one word.
- R4: Status bit 1 (rdy) of core c is 1 exactly when queue c holds fewer than DEPTH words. After reset every status word is 4'b0010, both interrupts are low and both read-data outputs are zero.
- R5: A push from core c while queue c is full is dropped and leaves the queue contents unchanged. It sets status bit 2 (wof) of core c, and that bit stays set until cleared.
- R6: A pop from core c while queue 1-c is empty returns zero and moves no pointer. It sets status bit 3 (roe) of core c, and that bit stays set until cleared.
- R7: A status clear strobe from core c clears wof and roe of core c only. If a new error of the same kind happens in the same cycle, the flag stays set.
- R8: `irq_o[c]` equals vld OR wof OR roe of core c.
- R9: A push and a pop on the same queue in the same cycle are both accepted when the queue is neither full nor empty, and the occupancy does not change.
- R10: The two queues and the two sets of flags behave independently when both cores act in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 2 | Per-core write strobe for the data register |
| wdata_i | input | 2x32 | Per-core word to push |
| pop_i | input | 2 | Per-core read strobe for the data register |
| rdata_o | output | 2x32 | Per-core head of the RX queue, zero when empty |
| stclr_i | input | 2 | Per-core status-register write (clears sticky flags) |
| status_o | output | 2x4 | Per-core {roe, wof, rdy, vld} |
| irq_o | output | 2 | Per-core interrupt |

## Verification
The bench fills a queue past its limit. A design that accepted the extra word would corrupt the word order seen by the other core, and a design that missed the error would leave wof low. It also reads an empty queue. A design that moved the pointer there would lose or repeat words later. Clears are issued on one core while the other core's flags are set, and also in the same cycle as a fresh error. A design with shared flags, or one where the clear wins, shows the wrong status bits. Random traffic with same-cycle pushes and pops on both cores, at the full and empty boundaries, catches occupancy counts that drift.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned NCORE = 2;
  localparam int unsigned ST_W  = 4;
  // Status word layout: {roe, wof, rdy, vld}
  typedef struct packed {
    logic roe;
    logic wof;
    logic rdy;
    logic vld;
  } mbox_stat_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          push_err_o,
  output logic          pop_err_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o     = (count_q == CW'(DEPTH));
  assign empty_o    = (count_q == '0);
  assign do_push    = push_i && !full_o;
  assign do_pop     = pop_i && !empty_o;
  assign push_err_o = push_i && full_o;
  assign pop_err_o  = pop_i && empty_o;
  assign rdata_o    = empty_o ? '0 : mem_q[rptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= bump(wptr_q);
      if (do_pop)  rptr_q <= bump(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  // R1: occupancy never exceeds the depth
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  // R5: a push into a full queue leaves occupancy unchanged
  a_r5_full_push_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (count_q == $past(count_q)));
  // R6: a pop from an empty queue leaves the pointers where they were
  a_r6_empty_pop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> ($stable(rptr_q) && $stable(wptr_q)));
  // R9: simultaneous push and pop keep occupancy steady
  a_r9_pushpop_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o) |=> (count_q == $past(count_q)));
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_wof_i,
  input  logic set_roe_i,
  input  logic clr_i,
  output logic wof_o,
  output logic roe_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wof_o <= 1'b0;
      roe_o <= 1'b0;
    end else begin
      wof_o <= set_wof_i || (wof_o && !clr_i);
      roe_o <= set_roe_i || (roe_o && !clr_i);
    end
  end

  // R5: wof stays set without a clear
  a_r5_wof_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wof_o && !clr_i) |=> wof_o);
  // R6: roe stays set without a clear
  a_r6_roe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roe_o && !clr_i) |=> roe_o);
  // R7: a clear with no new error empties both flags
  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_wof_i && !set_roe_i) |=> (!wof_o && !roe_o));
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCORE-1:0]           push_i,
  input  logic [NCORE-1:0][DW-1:0]   wdata_i,
  input  logic [NCORE-1:0]           pop_i,
  output logic [NCORE-1:0][DW-1:0]   rdata_o,
  input  logic [NCORE-1:0]           stclr_i,
  output logic [NCORE-1:0][ST_W-1:0] status_o,
  output logic [NCORE-1:0]           irq_o
);
  // Queue q is filled by core q and drained by core NCORE-1-q.
  logic [NCORE-1:0][DW-1:0] q_head;
  logic [NCORE-1:0]         q_full, q_empty, q_perr, q_uerr;
  logic [NCORE-1:0]         wof, roe;

  for (genvar q = 0; q < NCORE; q++) begin : g_queue
    localparam int unsigned DRAIN = NCORE - 1 - q;
    mbox_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .push_i     (push_i[q]),
      .wdata_i    (wdata_i[q]),
      .pop_i      (pop_i[DRAIN]),
      .rdata_o    (q_head[q]),
      .full_o     (q_full[q]),
      .empty_o    (q_empty[q]),
      .push_err_o (q_perr[q]),
      .pop_err_o  (q_uerr[q])
    );
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    localparam int unsigned RXQ = NCORE - 1 - c;
    mbox_stat_t st;
    mbox_flags u_flags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_wof_i (q_perr[c]),
      .set_roe_i (q_uerr[RXQ]),
      .clr_i     (stclr_i[c]),
      .wof_o     (wof[c]),
      .roe_o     (roe[c])
    );
    assign st.vld      = !q_empty[RXQ];
    assign st.rdy      = !q_full[c];
    assign st.wof      = wof[c];
    assign st.roe      = roe[c];
    assign status_o[c] = st;
    assign rdata_o[c]  = q_head[RXQ];
    assign irq_o[c]    = st.vld || st.wof || st.roe;

    // R2: with nothing waiting, the read data is zero
    a_r2_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !st.vld |-> (rdata_o[c] == '0));
    // R8: an error seen by this core raises its interrupt on the next cycle
    a_r8_err_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_perr[c] || q_uerr[RXQ]) |=> irq_o[c]);
  end
endmodule

// File: tb/mbox_pair_tb_top.sv
module mbox_pair_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]         push, pop, stclr;
  logic [1:0][DW-1:0] wdata;
  logic [1:0][DW-1:0] rdata;
  logic [1:0][3:0]    status;
  logic [1:0]         irq;

  always #10 clk = ~clk;  // 50 MHz

  mbox_pair #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .wdata_i(wdata),
    .pop_i(pop), .rdata_o(rdata), .stclr_i(stclr), .status_o(status), .irq_o(irq)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Reference model
  logic [DW-1:0] mq0[$];
  logic [DW-1:0] mq1[$];
  logic [1:0] m_wof = '0, m_roe = '0;

  function automatic int qsize(input int q);
    return (q == 0) ? mq0.size() : mq1.size();
  endfunction
  function automatic logic [DW-1:0] qhead(input int q);
    if (qsize(q) == 0) return '0;
    return (q == 0) ? mq0[0] : mq1[0];
  endfunction
  function automatic logic [3:0] exp_status(input int c);
    return {m_roe[c], m_wof[c], qsize(c) < DEPTH, qsize(1 - c) != 0};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int c = 0; c < 2; c++) begin
      logic [3:0] es;
      es = exp_status(c);
      check($sformatf("R3 vld core%0d", c), DW'(status[c][0]), DW'(es[0]));
      check($sformatf("R4 rdy core%0d", c), DW'(status[c][1]), DW'(es[1]));
      check($sformatf("R5 wof core%0d", c), DW'(status[c][2]), DW'(es[2]));
      check($sformatf("R6 roe core%0d", c), DW'(status[c][3]), DW'(es[3]));
      check($sformatf("R8 irq core%0d", c), DW'(irq[c]), DW'(es[0] | es[2] | es[3]));
      check($sformatf("R2 rdata core%0d", c), rdata[c], qhead(1 - c));
    end
  endtask

  // Drive one cycle at a falling edge, update the model at the rising edge,
  // then compare at the next falling edge.
  task automatic step(input logic [1:0] pu, input logic [1:0] po, input logic [1:0] cl,
                      input logic [DW-1:0] d0, input logic [DW-1:0] d1);
    logic [1:0] full_pre, empty_pre;
    push = pu; pop = po; stclr = cl; wdata[0] = d0; wdata[1] = d1;
    for (int c = 0; c < 2; c++) begin
      full_pre[c]  = (qsize(c) == DEPTH);
      empty_pre[c] = (qsize(1 - c) == 0);
    end
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      logic sw, sr;
      sw = pu[c] && full_pre[c];
      sr = po[c] && empty_pre[c];
      m_wof[c] = sw | (m_wof[c] & !cl[c]);
      m_roe[c] = sr | (m_roe[c] & !cl[c]);
    end
    if (po[1] && !empty_pre[1]) void'(mq0.pop_front());
    if (po[0] && !empty_pre[0]) void'(mq1.pop_front());
    if (pu[0] && !full_pre[0]) mq0.push_back(d0);
    if (pu[1] && !full_pre[1]) mq1.push_back(d1);
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    int seed;
    push = '0; pop = '0; stclr = '0; wdata = '0;
    seed = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state
    check("R4 reset status core0", DW'(status[0]), DW'(4'b0010));
    check("R4 reset status core1", DW'(status[1]), DW'(4'b0010));
    check("R4 reset irq", DW'(irq), '0);
    check("R4 reset rdata", rdata[0] | rdata[1], '0);

    // R1/R5: fill queue 0 and overflow it
    for (int i = 0; i < DEPTH + 1; i++) step(2'b01, 2'b00, 2'b00, 32'hA000_0000 + i, '0);
    check("R5 wof set after overflow", DW'(status[0][2]), 1);
    check("R1 order head word", rdata[1], 32'hA000_0000);
    // R6: core 0 reads its empty RX queue
    step(2'b00, 2'b01, 2'b00, '0, '0);
    check("R6 empty read zero", rdata[0], '0);
    // R1/R2: drain queue 0 in order, then underflow on core 1
    for (int i = 0; i < DEPTH; i++) begin
      check("R1 fifo order", rdata[1], 32'hA000_0000 + i);
      step(2'b00, 2'b10, 2'b00, '0, '0);
    end
    step(2'b00, 2'b10, 2'b00, '0, '0);
    check("R6 roe core1", DW'(status[1][3]), 1);
    // R7: clearing core 0 leaves core 1 flags intact
    step(2'b00, 2'b00, 2'b01, '0, '0);
    check("R7 core0 cleared", DW'(status[0][3:2]), 0);
    check("R7 core1 untouched", DW'(status[1][3]), 1);
    // R7: clear together with a fresh underflow keeps roe set
    step(2'b00, 2'b10, 2'b10, '0, '0);
    check("R7 set wins over clear", DW'(status[1][3]), 1);
    step(2'b00, 2'b00, 2'b10, '0, '0);
    check("R7 cleared core1", DW'(status[1][3:2]), 0);
    // R9/R10: both cores push and pop together
    step(2'b11, 2'b00, 2'b00, 32'h11, 32'h22);
    step(2'b11, 2'b11, 2'b00, 32'h33, 32'h44);
    check("R9 occupancy steady q0 head", rdata[1], 32'h33);
    check("R10 independent q1 head", rdata[0], 32'h44);

    // Random traffic with phases biased toward full and empty
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] pu, po, cl;
      int bias;
      bias = ((i / 200) % 2 == 0) ? 75 : 25;
      for (int c = 0; c < 2; c++) begin
        pu[c] = ($urandom % 100) < bias;
        po[c] = ($urandom % 100) < (100 - bias);
        cl[c] = ($urandom % 100) < 5;
      end
      step(pu, po, cl, $urandom, $urandom);  // R9 R10 under random mix
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule